// File: doc/BRIEF.md
# Watchdog Counter with Sticky Reset-Cause Flag

This block is an 8-bit watchdog counter that a CPU reads and writes over a small synchronous register bus. The counter counts up once on every clock cycle where the selected prescaler tick is high. A 3-bit clock-select field picks one of eight tick inputs. If software does not reload the counter before it wraps from 0xFF to 0x00, the block drives an internal chip-reset output high for a fixed number of clocks. It also latches a reset-cause flag.

The flag is sticky. The internal reset pulse does not clear it, so software can still read why the chip restarted. Only two things clear the flag: the external reset pin, or a guarded software write. A guarded write only works if the stored write-enable bit is already 1 and the same write carries 0 in the flag's inhibit bit.

Register map:

| Address | Register | Bits |
|---|---|---|
| 0 | Control/status | bit 7 = write enable (stored); bit 1 = flag inhibit (not stored); bit 0 = reset-cause flag; all other bits read 0 |
| 1 | Counter | 8-bit counter |
| 2 | Clock select | bits 2:0 = select; bits 7:3 read 1 |
| 3 | Unused | reads 0 |

Top module: `wdt_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the registers read as follows, and `chip_rst_o` is low:
  - control/status (address 0) reads 0x02;
  - counter (address 1) reads 0x00;
  - clock select (address 2) reads 0xFF.
- R2: Outside a reset pulse, the counter increments by one at each clock edge where `tick_in[sel]` is high, `sel` being the clock-select bits 2:0. When that tick is low, the counter holds its value.
- R3: A write to address 1 loads `bus_wdata` into the counter at that edge. This write overrides a tick in the same cycle.
- R4: When a tick takes the counter from 0xFF to 0x00, `chip_rst_o` goes high in the next cycle. It stays high for exactly PULSE_CYC (default 4) cycles.
- R5: The same overflow edge sets the flag (address 0, bit 0) to 1. The flag stays 1 through the internal reset pulse. If an overflow and a clearing write happen in the same cycle, the set wins.
- R6: Driving `rst_n` low clears the flag.
- R7: A write to address 0 stores `bus_wdata[7]` as the write enable. The same write clears the flag only if both of these hold:
  - the write enable was already 1 before the write;
  - `bus_wdata[1:0]` are both 0.

  In every other case the flag is unchanged. Writing 1 to bit 0 never sets the flag.
- R8: Address 0, bit 1 (the inhibit bit) always reads 1, whatever was written to it.
- R9: Address 2, bits 7:3 always read 1 and ignore writes. Bits 2:0 take the value written.
- R10: While `chip_rst_o` is high:
  - the counter is held at 0;
  - the clock select returns to 7;
  - the write enable is cleared;
  - all bus writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset pin, active low, asynchronous |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| tick_in | input | 8 | Prescaler tick inputs |
| chip_rst_o | output | 1 | Internal chip-reset pulse |

## Verification
The bench targets the following corner cases:

- **Counter write in the same cycle as a tick.** A design that lets the tick win would read back the written value plus one.
- **The overflow edge.** A design that pulses one cycle early, or for the wrong length, would fail the exact-width pulse check.
- **Flag clearing.** A design that clears the flag with the internal pulse, or on an unguarded write (enable off, or inhibit written as 1), would lose the reset cause. The bench also checks that the enable bit is sampled before the write, not taken from the same write.
- **Reserved and inhibit bits.** These are checked after random writes, which exposes any design that stores bits it should not.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CNT_W  = 8;
    localparam int SEL_W  = 3;
    localparam int ADDR_W = 2;
    localparam int NUM_TICKS = 1 << SEL_W;

    localparam logic [ADDR_W-1:0] ADDR_CSR = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CNT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_SEL = 2'd2;

    localparam int CSR_EN_BIT   = 7;
    localparam int CSR_INH_BIT  = 1;
    localparam int CSR_FLAG_BIT = 0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] sel;
        logic             en;
        logic             flag;
    } wdt_state_t;
endpackage

// File: rtl/wdt_tick_mux.sv
module wdt_tick_mux #(
    parameter int SEL_W = 3,
    localparam int N = 1 << SEL_W
) (
    input  logic [N-1:0]     tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);
    logic [N-1:0] hit;
    for (genvar i = 0; i < N; i++) begin : g_sel
        assign hit[i] = tick_in[i] && (sel == SEL_W'(i));
    end
    assign tick_o = |hit;
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
    parameter int PULSE_CYC = 4,
    localparam int PW = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse_o
);
    logic [PW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (start)
            left_d = PW'(PULSE_CYC);
        else if (left_q != '0)
            left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) left_q <= '0;
        else        left_q <= left_d;
    end

    assign pulse_o = (left_q != '0);

    // R4
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pulse_o);
    // R4
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q == PW'(1) && !start) |=> !pulse_o);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
    import wdt_pkg::*;
#(
    parameter int PULSE_CYC = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_we,
    input  logic [CNT_W-1:0]     bus_wdata,
    output logic [CNT_W-1:0]     bus_rdata,
    input  logic [NUM_TICKS-1:0] tick_in,
    output logic                 chip_rst_o
);
    wdt_state_t state_d, state_q;
    logic sel_tick, in_pulse, cnt_wr, ovf, guard_clr;

    wdt_tick_mux #(.SEL_W(SEL_W)) u_mux (
        .tick_in(tick_in), .sel(state_q.sel), .tick_o(sel_tick));

    wdt_rst_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk(clk), .rst_n(rst_n), .start(ovf), .pulse_o(in_pulse));

    assign chip_rst_o = in_pulse;

    always_comb begin
        state_d   = state_q;
        cnt_wr    = bus_we && (bus_addr == ADDR_CNT) && !in_pulse;
        ovf       = !cnt_wr && !in_pulse && sel_tick && (state_q.cnt == '1);
        guard_clr = 1'b0;
        if (in_pulse) begin
            state_d.cnt = '0;
            state_d.sel = '1;
            state_d.en  = 1'b0;
        end else begin
            if (cnt_wr)
                state_d.cnt = bus_wdata;
            else if (sel_tick)
                state_d.cnt = state_q.cnt + 1'b1;
            if (bus_we && bus_addr == ADDR_CSR) begin
                state_d.en = bus_wdata[CSR_EN_BIT];
                guard_clr  = state_q.en && !bus_wdata[CSR_INH_BIT]
                             && !bus_wdata[CSR_FLAG_BIT];
                if (guard_clr) state_d.flag = 1'b0;
            end
            if (bus_we && bus_addr == ADDR_SEL)
                state_d.sel = bus_wdata[SEL_W-1:0];
        end
        if (ovf) state_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '{cnt: '0, sel: '1, en: 1'b0, flag: 1'b0};
        else        state_q <= state_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CSR: begin
                bus_rdata[CSR_EN_BIT]   = state_q.en;
                bus_rdata[CSR_INH_BIT]  = 1'b1;
                bus_rdata[CSR_FLAG_BIT] = state_q.flag;
            end
            ADDR_CNT: bus_rdata = state_q.cnt;
            ADDR_SEL: bus_rdata = {{(CNT_W-SEL_W){1'b1}}, state_q.sel};
            default:  bus_rdata = '0;
        endcase
    end

    // R3
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> state_q.cnt == $past(bus_wdata));
    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (state_q.flag && chip_rst_o));
    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state_q.flag) |-> $past(bus_we && bus_addr == ADDR_CSR
            && bus_wdata[1:0] == 2'b00 && state_q.en && !chip_rst_o));
    // R10
    pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_o |=> (state_q.cnt == '0 && !state_q.en));
    // R9
    sel_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_SEL) |-> bus_rdata[CNT_W-1:SEL_W] == '1);
endmodule

// File: tb/sim_wdt_top.sv
module sim_wdt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tick_in = '0;
    logic       chip_rst_o;

    int total = 0;
    int bad = 0;

    logic [7:0] m_cnt;
    logic [2:0] m_sel;
    logic       m_en, m_flag;
    int         m_pulse;

    wdt_top #(.PULSE_CYC(4)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_in(tick_in),
        .chip_rst_o(chip_rst_o));

    always #5 clk = ~clk;

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0:    return {m_en, 5'b0, 1'b1, m_flag};
            2'd1:    return m_cnt;
            2'd2:    return {5'b11111, m_sel};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string addr_tag(input logic [1:0] a);
        case (a)
            2'd0: return "R7";
            2'd1: return "R2";
            2'd2: return "R9";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cnt = 8'h00; m_sel = 3'd7; m_en = 1'b0; m_flag = 1'b0; m_pulse = 0;
    endtask

    task automatic model_step(input logic we, input logic [1:0] a,
                              input logic [7:0] wd, input logic [7:0] tk);
        logic cw, ovf, clr;
        if (m_pulse > 0) begin
            m_pulse--; m_cnt = 0; m_sel = 3'd7; m_en = 1'b0;
        end else begin
            cw  = we && a == 2'd1;
            ovf = !cw && tk[m_sel] && m_cnt == 8'hFF;
            if (cw) m_cnt = wd;
            else if (tk[m_sel]) m_cnt = m_cnt + 8'd1;
            if (we && a == 2'd0) begin
                clr = m_en && !wd[1] && !wd[0];
                m_en = wd[7];
                if (clr) m_flag = 1'b0;
            end
            if (we && a == 2'd2) m_sel = wd[2:0];
            if (ovf) begin m_flag = 1'b1; m_pulse = 4; end
        end
    endtask

    // Called at a negedge; returns at the next negedge after checking.
    task automatic step(input logic we, input logic [1:0] a,
                        input logic [7:0] wd, input logic [7:0] tk);
        bus_we = we; bus_addr = a; bus_wdata = wd; tick_in = tk;
        @(posedge clk);
        model_step(we, a, wd, tk);
        @(negedge clk);
        chk(addr_tag(a), bus_rdata, exp_read(a));
        chk("R4", {7'b0, chip_rst_o}, {7'b0, m_pulse > 0});
    endtask

    task automatic peek(input string tag, input logic [1:0] a);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp_read(a));
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_we = 1'b0; tick_in = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        do_reset();
        // R1 reset values
        peek("R1", 2'd0); peek("R1", 2'd1); peek("R1", 2'd2);
        chk("R1", {7'b0, chip_rst_o}, 8'h00);

        // R8 inhibit bit reads 1 after writing 0
        step(1'b1, 2'd0, 8'h00, 8'h00);
        peek("R8", 2'd0);
        chk("R8", {7'b0, bus_rdata[1]}, 8'h01);

        // R2 only the selected tick (7) counts
        for (int i = 0; i < 3; i++) step(1'b0, 2'd1, 8'h00, 8'h7F);
        peek("R2", 2'd1);
        for (int i = 0; i < 3; i++) step(1'b0, 2'd1, 8'h00, 8'h80);
        chk("R2", bus_rdata, 8'h03);

        // R3 write beats tick
        step(1'b1, 2'd1, 8'h10, 8'hFF);
        chk("R3", bus_rdata, 8'h10);

        // R9 select write, reserved bits stay 1
        step(1'b1, 2'd2, 8'h02, 8'h00);
        chk("R9", bus_rdata, 8'hFA);

        // R4 R5 R10 overflow on tick 2
        step(1'b1, 2'd1, 8'hFF, 8'h00);
        step(1'b0, 2'd1, 8'h00, 8'h04);
        chk("R4", {7'b0, chip_rst_o}, 8'h01);
        peek("R5", 2'd0);
        chk("R5", {7'b0, bus_rdata[0]}, 8'h01);
        step(1'b1, 2'd1, 8'h55, 8'hFF);
        chk("R10", bus_rdata, 8'h00);
        step(1'b1, 2'd2, 8'h01, 8'hFF);
        step(1'b0, 2'd0, 8'h00, 8'hFF);
        chk("R4", {7'b0, chip_rst_o}, 8'h01);
        step(1'b0, 2'd0, 8'h00, 8'h00);
        chk("R4", {7'b0, chip_rst_o}, 8'h00);
        chk("R5", {7'b0, bus_rdata[0]}, 8'h01);
        peek("R10", 2'd2);
        chk("R10", bus_rdata, 8'hFF);

        // R7 guarded clear
        step(1'b1, 2'd0, 8'h00, 8'h00);
        chk("R7", {7'b0, bus_rdata[0]}, 8'h01);
        step(1'b1, 2'd0, 8'h80, 8'h00);
        chk("R7", {7'b0, bus_rdata[0]}, 8'h01);
        step(1'b1, 2'd0, 8'h82, 8'h00);
        chk("R7", {7'b0, bus_rdata[0]}, 8'h01);
        step(1'b1, 2'd0, 8'h81, 8'h00);
        chk("R7", {7'b0, bus_rdata[0]}, 8'h01);
        step(1'b1, 2'd0, 8'h80, 8'h00);
        chk("R7", {7'b0, bus_rdata[0]}, 8'h00);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic       we;
            logic [1:0] a;
            logic [7:0] wd, tk;
            we = ($urandom_range(0, 9) < 3);
            a  = 2'($urandom_range(0, 3));
            wd = 8'($urandom);
            if (a == 2'd1 && $urandom_range(0, 1) == 1) wd = 8'hF8 | wd[2:0];
            tk = 8'($urandom) | 8'($urandom);
            step(we, a, wd, tk);
        end

        // R6 external reset clears flag set by an overflow
        step(1'b1, 2'd1, 8'hFF, 8'h00);
        step(1'b0, 2'd0, 8'h00, 8'h80);
        chk("R6", {7'b0, bus_rdata[0]}, 8'h01);
        do_reset();
        peek("R6", 2'd0);
        chk("R6", bus_rdata, 8'h02);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule